// File: doc/BRIEF.md
# Reset Pulse Duration Counter

The block measures how long an active-low external reset pin is held low, so that software can tell a brief tap from a long factory-reset press. The pin is brought into the reference clock domain through a short flip-flop chain. Each reference clock cycle that the synchronized pin is low adds one to a saturating counter. At the default 25 MHz reference, one count is 40 ns, and the default 29-bit counter covers roughly 21.4 seconds.

The count is not cleared when the pin goes high again. It keeps its value until software writes a clear command. If the pin goes low again before a clear, counting continues from the held value.

A threshold register holds a whole number of seconds. A long-press output goes high once the count reaches that number of seconds times the ticks-per-second constant. A threshold of zero turns the output off.

Top module: `rst_dur_meter`

## Requirements
- R1: After reset the count reads 0, the threshold reads 0 and `long_press_o` is low.
- R2: `ext_rst_ni` passes through `SYNC_STAGES` (default 2) flip-flops before it gates counting. When the pin goes low, the count first changes at the third rising edge after the pin's value is first sampled low.
- R3: While the synchronized pin is low, the count rises by exactly one per clock. A low pulse lasting L clock cycles adds exactly L to the count.
- R4: The count saturates at 2^`CNT_W`-1 and stays there while the pin remains low.
- R5: While the pin is high, the count holds its value. A later low period without a clear adds to the held value.
- R6: Register address 0 is the count/control register. A write to it with data bit 31 set to 1 clears the count to 0. A write to it with bit 31 set to 0 leaves the count unchanged.
- R7: A read returns a zero-extended value in every bit not listed here. Address 0 returns the count in bits `CNT_W`-1:0. Address 1 returns the threshold in bits `THR_W`-1:0.
- R8: A write to address 1 loads the threshold from data bits `THR_W`-1:0. When the threshold is nonzero, `long_press_o` is high exactly when count ≥ threshold × `TICKS_PER_SEC`. The output lags the count by one clock.
- R9: A threshold of 0 holds `long_press_o` low whatever the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| ext_rst_ni | input | 1 | Asynchronous active-low pin being timed |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 count/control, 1 threshold |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on `reg_addr_i`) |
| long_press_o | output | 1 | Count has reached the threshold |

## Verification
The bench runs with a small counter width and a small ticks-per-second value, so that saturation and second boundaries can be reached in few cycles. A table of pulse lengths and thresholds covers the following cases:
- a single-cycle pulse, to show exact cycle counting;
- pulses one count below and exactly at the threshold, to separate the ≥ comparison from a > comparison;
- a pulse longer than the counter range, to show that the count saturates instead of wrapping.

Directed cases check:
- synchronizer latency, counted edge by edge;
- that the count holds after the pin is released;
- that a second pulse without a clear adds to the held count;
- that a control write without bit 31 leaves the count unchanged.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  localparam int DATA_W  = 32;
  localparam int CLR_BIT = 31;

  typedef enum logic {
    ADDR_CNT = 1'b0,
    ADDR_THR = 1'b1
  } rdm_addr_e;
endpackage

// File: rtl/rdm_sync.sv
module rdm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic sync_no
);
  logic [STAGES-1:0] chain_q;

  // reset to the inactive (high) level so no count starts on reset exit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], async_ni};
  end

  assign sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/rdm_cnt.sv
module rdm_cnt #(
  parameter int CNT_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (inc_i && !at_max) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rdm_thr.sv
module rdm_thr #(
  parameter int CNT_W         = 29,
  parameter int THR_W         = 8,
  parameter int TICKS_PER_SEC = 25_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [THR_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [THR_W-1:0] thr_o,
  output logic             flag_o
);
  localparam int TICK_W = $clog2(TICKS_PER_SEC + 1);
  localparam int PROD_W = THR_W + TICK_W;
  localparam int CMP_W  = (PROD_W > CNT_W) ? PROD_W : CNT_W;

  logic [THR_W-1:0]  thr_q;
  logic [PROD_W-1:0] limit;
  logic              reached;
  logic              flag_q;

  assign limit   = PROD_W'(thr_q) * PROD_W'(TICKS_PER_SEC);
  assign reached = (thr_q != '0) && (CMP_W'(cnt_i) >= CMP_W'(limit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (we_i) thr_q <= wdata_i;
      flag_q <= reached;
    end
  end

  assign thr_o  = thr_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/rst_dur_meter.sv
module rst_dur_meter #(
  parameter int CNT_W         = 29,
  parameter int THR_W         = 8,
  parameter int TICKS_PER_SEC = 25_000_000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ext_rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        long_press_o
);
  import rdm_pkg::*;

  rdm_addr_e        addr;
  logic             sync_n;
  logic             sync_low;
  logic             clr;
  logic             thr_we;
  logic [CNT_W-1:0] cnt_q;
  logic [THR_W-1:0] thr_q;
  logic             unused_wdata;

  assign addr     = rdm_addr_e'(reg_addr_i);
  assign clr      = reg_we_i && (addr == ADDR_CNT) && reg_wdata_i[CLR_BIT];
  assign thr_we   = reg_we_i && (addr == ADDR_THR);
  assign sync_low = !sync_n;
  assign unused_wdata = ^reg_wdata_i[CLR_BIT-1:THR_W];

  rdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_ni (ext_rst_ni),
    .sync_no  (sync_n)
  );

  rdm_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (sync_low),
    .cnt_o  (cnt_q)
  );

  rdm_thr #(
    .CNT_W         (CNT_W),
    .THR_W         (THR_W),
    .TICKS_PER_SEC (TICKS_PER_SEC)
  ) u_thr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (thr_we),
    .wdata_i (reg_wdata_i[THR_W-1:0]),
    .cnt_i   (cnt_q),
    .thr_o   (thr_q),
    .flag_o  (long_press_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (addr)
      ADDR_CNT: reg_rdata_o[CNT_W-1:0] = cnt_q;
      ADDR_THR: reg_rdata_o[THR_W-1:0] = thr_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rdm_checker.sv
module rdm_checker #(
  parameter int CNT_W = 29,
  parameter int THR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic             reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             sync_low,
  input logic [CNT_W-1:0] cnt_q,
  input logic [THR_W-1:0] thr_q,
  input logic             long_press_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic clr_req;
  assign clr_req = reg_we_i && !reg_addr_i && reg_wdata_i[31];

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_low && !clr_req && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_req) |=> (cnt_q == CNT_MAX));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_low && !clr_req) |=> $stable(cnt_q));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req |=> (cnt_q == '0));

  assert_zero_thr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_q == '0) |=> !long_press_o);
endmodule

bind rst_dur_meter rdm_checker #(.CNT_W(CNT_W), .THR_W(THR_W)) u_rdm_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .sync_low     (sync_low),
  .cnt_q        (cnt_q),
  .thr_q        (thr_q),
  .long_press_o (long_press_o)
);

// File: tb/rst_dur_meter_bench.sv
module rst_dur_meter_bench;
  localparam int CNT_W = 6;
  localparam int THR_W = 4;
  localparam int TPS   = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;
  localparam int NV    = 8;
  localparam int VEC_L [NV] = '{1, 5, 3, 8, 7, 63, 80, 20};
  localparam int VEC_T [NV] = '{0, 1, 1, 2, 2, 15, 15, 6};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_n = 1'b1;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lp;
  int          n_run = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  rst_dur_meter #(.CNT_W(CNT_W), .THR_W(THR_W), .TICKS_PER_SEC(TPS), .SYNC_STAGES(2))
  u_rst_dur_meter (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(ext_n), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .long_press_o(lp)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic a, output int v);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic pulse(input int len);
    @(negedge clk);
    ext_n = 1'b0;
    repeat (len) @(negedge clk);
    ext_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v;
    int exp_c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, v); chk("R1 count", v, 0);
    rd(1'b1, v); chk("R1 threshold", v, 0);
    chk("R1 flag", int'(lp), 0);

    // table: R3 exact count, R4 saturation, R8 threshold boundary, R9 disable
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, 32'h8000_0000);
      wr(1'b1, 32'(VEC_T[i]));
      pulse(VEC_L[i]);
      exp_c = (VEC_L[i] > CMAX) ? CMAX : VEC_L[i];
      rd(1'b0, v); chk("R3/R4 count", v, exp_c);
      chk("R8/R9 flag", int'(lp), int'(VEC_T[i] != 0 && exp_c >= VEC_T[i] * TPS));
    end

    // R7 threshold readback, upper bits zero
    wr(1'b1, 32'hFFFF_FFF9);
    rd(1'b1, v); chk("R7 threshold read", v, 9);

    // R2 synchronizer latency
    wr(1'b0, 32'h8000_0000);
    addr = 1'b0;
    @(negedge clk);
    ext_n = 1'b0;
    @(posedge clk); @(posedge clk);
    #1 chk("R2 no count after two edges", int'(rdata), 0);
    @(posedge clk);
    #1 chk("R2 count at third edge", int'(rdata), 1);
    @(negedge clk);
    ext_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 hold then accumulate
    wr(1'b0, 32'h8000_0000);
    pulse(5);
    repeat (20) @(negedge clk);
    rd(1'b0, v); chk("R5 hold after release", v, 5);
    pulse(3);
    rd(1'b0, v); chk("R5 accumulate", v, 8);

    // R6 write without bit 31 has no effect, then clear
    wr(1'b0, 32'h7FFF_FFFF);
    rd(1'b0, v); chk("R6 no clear without bit31", v, 8);
    wr(1'b0, 32'h8000_0000);
    rd(1'b0, v); chk("R6 clear", v, 0);

    // R9 zero threshold after saturation
    wr(1'b1, 32'h0);
    pulse(70);
    rd(1'b0, v); chk("R4 saturate", v, CMAX);
    chk("R9 flag off at zero threshold", int'(lp), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule